// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block feeds a MAC transmitter from a ring of transmit descriptors kept in memory. Each descriptor takes two 32-bit words. The word at offset 0 holds the byte address of a buffer. The word at offset 4 is a control word that carries the buffer length, frame flags and an ownership flag. Software fills descriptors, hands them over by clearing the ownership flag, and pulses `start_i`. The block then walks the ring from its current slot. For each owned descriptor it fetches the buffer one 32-bit word at a time and streams the bytes out with a ready/valid handshake. When a buffer has been sent, it writes the control word back with the ownership flag set, which returns the descriptor to software.

The walk stops when a descriptor is still marked as owned by software. It also stops at the end of a frame after a halt request, or after an error reported by the MAC. `busy_o` stays high for as long as the walk runs. The slot pointer survives every kind of stop, so the next start resumes at the slot where the walk stopped. Errors are reported in the control word as status bits: a MAC underrun, a retry limit, or a frame whose next buffer was not yet handed over. Appending the CRC and driving the line belong to the MAC; this block only passes on a per-buffer request to suppress the CRC.

Top module: `txq_desc_reader`

## Requirements
- R1: After reset `busy_o`, `tx_valid_o` and `mem_req_o` are low and the slot pointer is 0. Every memory access is a word-aligned byte address (bits 1:0 are 0).
- R2: On a start pulse while idle, the first access is a read of the control word at `ring_base_i + 8*slot + 4`. If that word is handed over, the next access reads the buffer address at `ring_base_i + 8*slot`. Control bits 10:0 give the buffer length in bytes.
- R3: A buffer emits exactly its length in bytes, in increasing address order, from any start alignment. Byte lane k of a memory word holds the byte at word address + k. A buffer of length 0 emits nothing. Buffers of one frame are emitted back to back.
- R4: When control bit 15 (end of frame) is set, `tx_last_o` is high on the final byte of that buffer and on no other byte. `tx_nocrc_o` follows control bit 16 on every byte of the buffer.
- R5: After a buffer's last byte is accepted, exactly one write goes to its control word. The written value is the fetched control word with bit 31 (owned by software) set and status bits 27, 28 and 29 cleared.
- R6: If the control word fetched at a frame boundary has bit 31 set, the block emits nothing, writes nothing, drops `busy_o` and keeps the slot pointer.
- R7: A descriptor with control bit 30 (ring end) set is followed by slot 0. Any other descriptor is followed by the next slot.
- R8: A halt request finishes the frame in progress and stops before fetching the next frame. The following start resumes at the next slot.
- R9: A pulse on `mac_underrun_i` or `mac_retry_i` while bytes are being offered aborts the buffer. The control word is written with bit 31 set plus bit 28 (underrun) or bit 29 (retry limit), `busy_o` drops, and the slot pointer is not advanced.
- R10: If the fetched control word has bit 31 set inside a frame (the previous buffer lacked bit 15), the first descriptor of the frame is rewritten with its control word plus bit 31 and bit 27 (ran out mid-frame), and the block stops.
- R11: A start pulse while `busy_o` is high has no effect. `busy_o` stays high from the cycle after an accepted start until the walk stops.
- R12: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o`, `tx_last_o` and `tx_nocrc_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ring_base_i | input | ADDR_W | Byte address of slot 0 of the ring |
| start_i | input | 1 | Start pulse, taken only when idle |
| halt_i | input | 1 | Halt request: stop at the next frame end |
| mac_underrun_i | input | 1 | MAC reports an underrun for the current buffer |
| mac_retry_i | input | 1 | MAC reports the retry limit reached |
| busy_o | output | 1 | Transmission in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| tx_valid_o | output | 1 | Byte offered to the MAC |
| tx_data_o | output | 8 | Byte value |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_nocrc_o | output | 1 | MAC must not append a CRC |
| tx_ready_i | input | 1 | MAC accepts the byte |

## Verification
The bench builds the block with a 10-bit address space and a 3-bit slot counter, and closes the ring after four slots with the ring-end bit. This keeps the whole memory small enough to model as a flat array. A sweep then covers every start alignment against buffer lengths 1 to 9, so every lane entry point and every word crossing is exercised, and the ring wraps many times. Memory acknowledges and MAC ready follow a pseudo-random stall pattern in one half of the sweep and run at full speed in the other. The bench then drives halt, underrun, retry limit and mid-frame exhaustion directly and predicts every written-back control word from the bit layout.

// File: rtl/txq_pkg.sv
package txq_pkg;

   // Control word field positions, fixed by the descriptor layout in memory
   localparam int CW_LEN_MSB  = 10;
   localparam int CW_LAST     = 15;
   localparam int CW_NOCRC    = 16;
   localparam int CW_EXHAUST  = 27;
   localparam int CW_UNDERRUN = 28;
   localparam int CW_RETRY    = 29;
   localparam int CW_WRAP     = 30;
   localparam int CW_USED     = 31;

   localparam int LEN_W = CW_LEN_MSB + 1;

   localparam logic [31:0] STATUS_MASK = (32'd1 << CW_EXHAUST)
                                       | (32'd1 << CW_UNDERRUN)
                                       | (32'd1 << CW_RETRY);

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_BADDR,
      ST_WORD,
      ST_EMIT,
      ST_DONE_WB,
      ST_FAIL_WB,
      ST_EXH_WB
   } seq_state_t;

endpackage

// File: rtl/txq_slot_ptr.sv
module txq_slot_ptr #(
   parameter int ADDR_W = 16,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              step_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] desc_addr_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam int OFF_W = SLOT_W + 3;

   generate
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("txq_slot_ptr: ring offset wider than address");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_q;
   logic [OFF_W-1:0]  off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (step_i) begin
         slot_q <= wrap_i ? '0 : slot_q + 1'b1;
      end
   end

   assign off         = {slot_q, 3'b000};
   assign desc_addr_o = base_i + ADDR_W'(off);
   assign slot_o      = slot_q;

   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && wrap_i) |=> (slot_o == '0));

endmodule

// File: rtl/txq_byte_lane.sv
module txq_byte_lane #(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  lane_i,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_ENDIAN) begin : g_be
         always_comb begin
            unique case (lane_i)
               2'd0:    byte_o = word_i[31:24];
               2'd1:    byte_o = word_i[23:16];
               2'd2:    byte_o = word_i[15:8];
               default: byte_o = word_i[7:0];
            endcase
         end
      end else begin : g_le
         always_comb begin
            unique case (lane_i)
               2'd0:    byte_o = word_i[7:0];
               2'd1:    byte_o = word_i[15:8];
               2'd2:    byte_o = word_i[23:16];
               default: byte_o = word_i[31:24];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/txq_seq.sv
module txq_seq
   import txq_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              halt_i,
   input  logic              mac_underrun_i,
   input  logic              mac_retry_i,
   input  logic [ADDR_W-1:0] desc_addr_i,
   output logic              step_o,
   output logic              wrap_o,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              tx_valid_o,
   output logic              tx_last_o,
   output logic              tx_nocrc_o,
   output logic [1:0]        lane_o,
   output logic [31:0]       word_o,
   input  logic              tx_ready_i
);
   localparam int BA_W = (ADDR_W < 32) ? ADDR_W : 32;

   seq_state_t         state_q;
   logic [31:0]        ctrl_q;
   logic [ADDR_W-1:0]  baddr_q;
   logic [LEN_W-1:0]   rem_q;
   logic [31:0]        word_q;
   logic               in_frame_q;
   logic [ADDR_W-1:0]  head_addr_q;
   logic [31:0]        head_ctrl_q;
   logic               halt_q;
   logic [1:0]         err_q;

   logic [ADDR_W-1:0]  ctrl_addr;
   logic               err_any;
   logic               stop_at_edge;

   function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
      return {a[ADDR_W-1:2], 2'b00};
   endfunction

   function automatic logic [31:0] owned_back(input logic [31:0] w);
      return (w & ~STATUS_MASK) | (32'd1 << CW_USED);
   endfunction

   assign ctrl_addr    = desc_addr_i + ADDR_W'(4);
   assign err_any      = mac_underrun_i | mac_retry_i;
   assign stop_at_edge = halt_q | halt_i;

   // Memory port
   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_wdata_o = '0;
      unique case (state_q)
         ST_CTRL: begin
            mem_req_o  = 1'b1;
            mem_addr_o = word_align(ctrl_addr);
         end
         ST_BADDR: begin
            mem_req_o  = 1'b1;
            mem_addr_o = word_align(desc_addr_i);
         end
         ST_WORD: begin
            mem_req_o  = 1'b1;
            mem_addr_o = word_align(baddr_q);
         end
         ST_DONE_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = word_align(ctrl_addr);
            mem_wdata_o = owned_back(ctrl_q);
         end
         ST_FAIL_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = word_align(ctrl_addr);
            mem_wdata_o = owned_back(ctrl_q)
                        | (32'(err_q[0]) << CW_UNDERRUN)
                        | (32'(err_q[1]) << CW_RETRY);
         end
         ST_EXH_WB: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = word_align(head_addr_q);
            mem_wdata_o = owned_back(head_ctrl_q) | (32'd1 << CW_EXHAUST);
         end
         default: ;
      endcase
   end

   // Ring pointer control and byte stream
   assign step_o     = (state_q == ST_DONE_WB) && mem_ack_i;
   assign wrap_o     = ctrl_q[CW_WRAP];
   assign busy_o     = (state_q != ST_IDLE);
   assign tx_valid_o = (state_q == ST_EMIT);
   assign tx_last_o  = tx_valid_o && (rem_q == LEN_W'(1)) && ctrl_q[CW_LAST];
   assign tx_nocrc_o = tx_valid_o && ctrl_q[CW_NOCRC];
   assign lane_o     = baddr_q[1:0];
   assign word_o     = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ctrl_q      <= '0;
         baddr_q     <= '0;
         rem_q       <= '0;
         word_q      <= '0;
         in_frame_q  <= 1'b0;
         head_addr_q <= '0;
         head_ctrl_q <= '0;
         halt_q      <= 1'b0;
         err_q       <= '0;
      end else begin
         if (halt_i && busy_o) begin
            halt_q <= 1'b1;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  halt_q  <= 1'b0;
                  state_q <= ST_CTRL;
               end
            end
            ST_CTRL: begin
               if (mem_ack_i) begin
                  if (halt_q && !in_frame_q) begin
                     state_q <= ST_IDLE;
                  end else if (mem_rdata_i[CW_USED]) begin
                     state_q <= in_frame_q ? ST_EXH_WB : ST_IDLE;
                  end else begin
                     ctrl_q     <= mem_rdata_i;
                     in_frame_q <= 1'b1;
                     if (!in_frame_q) begin
                        head_addr_q <= ctrl_addr;
                        head_ctrl_q <= mem_rdata_i;
                     end
                     state_q <= ST_BADDR;
                  end
               end
            end
            ST_BADDR: begin
               if (mem_ack_i) begin
                  baddr_q <= ADDR_W'(mem_rdata_i[BA_W-1:0]);
                  rem_q   <= ctrl_q[CW_LEN_MSB:0];
                  state_q <= (ctrl_q[CW_LEN_MSB:0] == '0) ? ST_DONE_WB : ST_WORD;
               end
            end
            ST_WORD: begin
               if (mem_ack_i) begin
                  word_q  <= mem_rdata_i;
                  state_q <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (err_any) begin
                  err_q   <= {mac_retry_i, mac_underrun_i};
                  state_q <= ST_FAIL_WB;
               end else if (tx_ready_i) begin
                  rem_q   <= rem_q - 1'b1;
                  baddr_q <= baddr_q + 1'b1;
                  if (rem_q == LEN_W'(1)) begin
                     state_q <= ST_DONE_WB;
                  end else if (baddr_q[1:0] == 2'b11) begin
                     state_q <= ST_WORD;
                  end
               end
            end
            ST_DONE_WB: begin
               if (mem_ack_i) begin
                  if (ctrl_q[CW_LAST]) begin
                     in_frame_q <= 1'b0;
                     state_q    <= stop_at_edge ? ST_IDLE : ST_CTRL;
                  end else begin
                     state_q <= ST_CTRL;
                  end
               end
            end
            ST_FAIL_WB, ST_EXH_WB: begin
               if (mem_ack_i) begin
                  in_frame_q <= 1'b0;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

   p_writeback_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> mem_wdata_o[CW_USED]);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !tx_valid_o));

   p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last_o |-> tx_valid_o);

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && err_any) |=> (mem_we_o && !tx_valid_o && !step_o));

endmodule

// File: rtl/txq_desc_reader.sv
module txq_desc_reader #(
   parameter int ADDR_W     = 16,
   parameter int SLOT_W     = 4,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ring_base_i,
   input  logic              start_i,
   input  logic              halt_i,
   input  logic              mac_underrun_i,
   input  logic              mac_retry_i,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              tx_valid_o,
   output logic [7:0]        tx_data_o,
   output logic              tx_last_o,
   output logic              tx_nocrc_o,
   input  logic              tx_ready_i
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("txq_desc_reader: ADDR_W must lie in 8..32");
      end
      if (SLOT_W < 1 || SLOT_W + 3 > ADDR_W) begin : g_bad_slot
         $error("txq_desc_reader: SLOT_W out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] desc_addr;
   logic [SLOT_W-1:0] slot;
   logic              step;
   logic              wrap;
   logic [1:0]        lane;
   logic [31:0]       word;

   txq_slot_ptr #(
      .ADDR_W (ADDR_W),
      .SLOT_W (SLOT_W)
   ) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .base_i      (ring_base_i),
      .step_i      (step),
      .wrap_i      (wrap),
      .desc_addr_o (desc_addr),
      .slot_o      (slot)
   );

   txq_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .halt_i         (halt_i),
      .mac_underrun_i (mac_underrun_i),
      .mac_retry_i    (mac_retry_i),
      .desc_addr_i    (desc_addr),
      .step_o         (step),
      .wrap_o         (wrap),
      .busy_o         (busy_o),
      .mem_req_o      (mem_req_o),
      .mem_we_o       (mem_we_o),
      .mem_addr_o     (mem_addr_o),
      .mem_wdata_o    (mem_wdata_o),
      .mem_ack_i      (mem_ack_i),
      .mem_rdata_i    (mem_rdata_i),
      .tx_valid_o     (tx_valid_o),
      .tx_last_o      (tx_last_o),
      .tx_nocrc_o     (tx_nocrc_o),
      .lane_o         (lane),
      .word_o         (word),
      .tx_ready_i     (tx_ready_i)
   );

   txq_byte_lane #(
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_lane (
      .word_i (word),
      .lane_i (lane),
      .byte_o (tx_data_o)
   );

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i && !mac_underrun_i && !mac_retry_i)
      |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o) && $stable(tx_nocrc_o)));

   p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> (slot == $past(slot)));

endmodule

// File: tb/txq_desc_reader_tb.sv
module txq_desc_reader_tb;
   localparam int AW  = 10;
   localparam int SW  = 3;
   localparam int RB  = 'h100;
   localparam int NSL = 4;
   localparam logic [31:0] USED = 32'h8000_0000;
   localparam logic [31:0] WRAP = 32'h4000_0000;
   localparam logic [31:0] RTRY = 32'h2000_0000;
   localparam logic [31:0] UNDR = 32'h1000_0000;
   localparam logic [31:0] EXHS = 32'h0800_0000;
   localparam logic [31:0] NOCR = 32'h0001_0000;
   localparam logic [31:0] LAST = 32'h0000_8000;
   localparam logic [31:0] STAT = 32'h3800_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, halt = 1'b0, undr = 1'b0, rtry = 1'b0;
   logic busy, mem_req, mem_we, mem_ack, tx_valid, tx_last, tx_nocrc, tx_ready;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [7:0] tx_data;

   logic [31:0] mem [0:255];
   logic [7:0]  lfsr = 8'h5a;
   logic        full_speed = 1'b1;
   logic        err_test = 1'b0;

   int checks = 0, errors = 0, cyc = 0;
   int ncap = 0, nwrites = 0;
   logic [7:0] cap [0:63];
   logic       caplast [0:63];
   logic       capnocrc [0:63];
   logic       hold_pend = 1'b0;
   logic [7:0] hold_data;
   logic       want_first = 1'b0;
   int         first_addr = -1;
   int         cur = 0;

   always #5 clk = ~clk;

   txq_desc_reader #(.ADDR_W(AW), .SLOT_W(SW), .BIG_ENDIAN(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .ring_base_i(AW'(RB)), .start_i(start), .halt_i(halt),
      .mac_underrun_i(undr), .mac_retry_i(rtry), .busy_o(busy),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_nocrc_o(tx_nocrc),
      .tx_ready_i(tx_ready));

   assign mem_rdata = mem[mem_addr[9:2]];
   assign mem_ack   = mem_req && (full_speed || lfsr[0] || lfsr[4]);
   assign tx_ready  = full_speed || lfsr[1] || lfsr[6];

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor, sampled on the falling edge
   always @(negedge clk) if (rst_n) begin
      if (want_first && mem_req) begin
         first_addr = int'(mem_addr);
         want_first = 1'b0;
      end
      if (hold_pend && !err_test)
         chk(tx_valid && tx_data == hold_data, "R12", "byte held under back-pressure",
             int'(tx_data), int'(hold_data));
      hold_pend = tx_valid && !tx_ready;
      hold_data = tx_data;
      if (tx_valid && tx_ready && ncap < 64) begin
         cap[ncap] = tx_data; caplast[ncap] = tx_last; capnocrc[ncap] = tx_nocrc;
         ncap++;
      end
      if (mem_req && mem_we && mem_ack) nwrites++;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL R11 watchdog expired: actual=%0h expected=%0h", busy, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13 + 5) & 255);
   endfunction

   function automatic int nxt(input int s);
      return (s == NSL - 1) ? 0 : s + 1;
   endfunction

   function automatic int cidx(input int s);
      return (RB >> 2) + 2 * s + 1;
   endfunction

   task automatic arm(input int s, input int baddr, input logic [31:0] flags, input int len);
      mem[(RB >> 2) + 2 * s] = 32'(baddr);
      mem[cidx(s)] = flags | 32'(len) | ((s == NSL - 1) ? WRAP : 32'h0);
   endtask

   task automatic run();
      ncap = 0; nwrites = 0; first_addr = -1;
      @(negedge clk); start = 1'b1; want_first = 1'b1;
      @(negedge clk); start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic chk_bytes(input string req, input int baddr, input int len, input int off);
      bit ok = 1'b1;
      int bad = 0;
      for (int k = 0; k < len; k++)
         if (cap[off + k] !== pat(baddr + k)) begin ok = 1'b0; bad = k; end
      chk(ok, req, "byte content", int'(cap[off + bad]), int'(pat(baddr + bad)));
   endtask

   initial begin
      for (int w = 0; w < 256; w++)
         mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      for (int s = 0; s < NSL; s++) begin
         mem[(RB >> 2) + 2 * s] = 32'h0;
         mem[cidx(s)] = USED | ((s == NSL - 1) ? WRAP : 32'h0);
      end
      repeat (3) @(negedge clk);
      chk(!busy && !tx_valid && !mem_req, "R1", "outputs in reset",
          int'({busy, tx_valid, mem_req}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !tx_valid && !mem_req, "R1", "idle after reset",
          int'({busy, tx_valid, mem_req}), 0);

      // R6: slot 0 still owned by software at start
      run();
      chk(ncap == 0, "R6", "bytes with owned slot", ncap, 0);
      chk(nwrites == 0, "R6", "writes with owned slot", nwrites, 0);
      chk(first_addr == RB + 4, "R2", "first fetch address", first_addr, RB + 4);

      // R3 R4 R5 R7: sweep alignment x length, wrapping the ring repeatedly
      for (int al = 0; al < 4; al++) begin
         for (int len = 1; len <= 9; len++) begin
            logic [31:0] fl, expw;
            int ba;
            bit lok, nok;
            full_speed = (len % 2 == 0);
            ba = 'h200 + 16 * len + al;
            fl = LAST | ((len % 3 == 0) ? (NOCR | UNDR) : 32'h0);
            arm(cur, ba, fl, len);
            expw = (mem[cidx(cur)] & ~STAT) | USED;
            run();
            chk(first_addr == RB + 8 * cur + 4, "R2", "control fetch address",
                first_addr, RB + 8 * cur + 4);
            chk(ncap == len, "R3", "byte count", ncap, len);
            chk_bytes("R3", ba, len, 0);
            lok = 1'b1; nok = 1'b1;
            for (int k = 0; k < len; k++) begin
               if (caplast[k] !== (k == len - 1)) lok = 1'b0;
               if (capnocrc[k] !== (len % 3 == 0)) nok = 1'b0;
            end
            chk(lok, "R4", "end marker placement", int'(lok), 1);
            chk(nok, "R4", "no-CRC flag", int'(nok), 1);
            chk(mem[cidx(cur)] == expw, "R5", "written-back control", int'(mem[cidx(cur)]), int'(expw));
            chk(nwrites == 1, "R5", "write count", nwrites, 1);
            cur = nxt(cur);   // R7: slot 3 carries the ring-end bit
         end
      end
      full_speed = 1'b1;

      // R3: multi-buffer frame with a zero-length middle buffer
      begin
         int s0, s1, s2;
         s0 = cur; s1 = nxt(s0); s2 = nxt(s1);
         arm(s0, 'h301, 32'h0, 5);
         arm(s1, 'h340, 32'h0, 0);
         arm(s2, 'h362, LAST, 6);
         full_speed = 1'b0;
         run();
         full_speed = 1'b1;
         chk(ncap == 11, "R3", "multi-buffer byte count", ncap, 11);
         chk_bytes("R3", 'h301, 5, 0);
         chk_bytes("R3", 'h362, 6, 5);
         chk(caplast[10] && !caplast[4], "R4", "end marker only on frame end",
             int'({caplast[4], caplast[10]}), 1);
         chk(nwrites == 3, "R5", "one write per buffer", nwrites, 3);
         chk(mem[cidx(s1)] == (USED | ((s1 == NSL-1) ? WRAP : 32'h0)), "R5", "zero-length write-back",
             int'(mem[cidx(s1)]), int'(USED | ((s1 == NSL-1) ? WRAP : 32'h0)));
         cur = nxt(s2);
      end

      // R8: halt during first of two frames
      begin
         int sa, sb;
         logic [31:0] cb;
         sa = cur; sb = nxt(sa);
         arm(sa, 'h280, LAST, 12);
         arm(sb, 'h2c0, LAST, 12);
         cb = mem[cidx(sb)];
         ncap = 0; nwrites = 0;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         while (ncap < 2) @(negedge clk);
         halt = 1'b1;
         @(negedge clk); halt = 1'b0;
         while (busy) @(negedge clk);
         chk(ncap == 12, "R8", "halted run finishes frame", ncap, 12);
         chk(mem[cidx(sb)] == cb, "R8", "next frame untouched", int'(mem[cidx(sb)]), int'(cb));
         run();
         chk(first_addr == RB + 8 * sb + 4, "R8", "resume slot", first_addr, RB + 8 * sb + 4);
         chk(ncap == 12, "R8", "second frame after restart", ncap, 12);
         chk_bytes("R8", 'h2c0, 12, 0);
         cur = nxt(sb);
      end

      // R9: underrun then retry limit, pointer kept
      begin
         logic [31:0] c0, expw;
         int n0;
         err_test = 1'b1;
         arm(cur, 'h200, LAST, 40);
         c0 = mem[cidx(cur)];
         ncap = 0; nwrites = 0;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         while (!(ncap >= 3 && tx_valid)) @(negedge clk);
         undr = 1'b1;
         @(negedge clk); undr = 1'b0;
         while (busy) @(negedge clk);
         n0 = ncap;
         expw = (c0 & ~STAT) | USED | UNDR;
         chk(n0 < 40, "R9", "underrun aborts buffer", n0, 40);
         chk(mem[cidx(cur)] == expw, "R9", "underrun status", int'(mem[cidx(cur)]), int'(expw));
         run();
         chk(ncap == 0 && nwrites == 0, "R9", "pointer kept after error", ncap + nwrites, 0);
         chk(first_addr == RB + 8 * cur + 4, "R9", "same slot refetched", first_addr, RB + 8 * cur + 4);

         arm(cur, 'h220, LAST | NOCR, 30);
         c0 = mem[cidx(cur)];
         ncap = 0;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         while (!(ncap >= 5 && tx_valid)) @(negedge clk);
         rtry = 1'b1;
         @(negedge clk); rtry = 1'b0;
         while (busy) @(negedge clk);
         expw = (c0 & ~STAT) | USED | RTRY;
         chk(mem[cidx(cur)] == expw, "R9", "retry status", int'(mem[cidx(cur)]), int'(expw));
         err_test = 1'b0;
      end

      // R10: frame runs out of handed-over buffers
      begin
         logic [31:0] c0, expw;
         int sn;
         arm(cur, 'h250, 32'h0, 4);
         c0 = mem[cidx(cur)];
         sn = nxt(cur);
         run();
         expw = (c0 & ~STAT) | USED | EXHS;
         chk(ncap == 4, "R10", "bytes before exhaustion", ncap, 4);
         chk(!caplast[3], "R10", "no end marker", int'(caplast[3]), 0);
         chk(mem[cidx(cur)] == expw, "R10", "head rewritten", int'(mem[cidx(cur)]), int'(expw));
         chk(nwrites == 2, "R10", "write count", nwrites, 2);
         cur = sn;
         arm(cur, 'h270, LAST, 3);
         run();
         chk(first_addr == RB + 8 * cur + 4, "R10", "resume at owned slot", first_addr, RB + 8 * cur + 4);
         chk(ncap == 3, "R10", "frame after resume", ncap, 3);
         cur = nxt(cur);
      end

      // R11: start while busy is ignored
      begin
         int ba;
         ba = 'h300;
         arm(cur, ba, LAST, 30);
         ncap = 0; nwrites = 0;
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk(busy, "R11", "busy after start", int'(busy), 1);
         while (ncap < 10) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
         chk(busy, "R11", "busy held through start", int'(busy), 1);
         while (busy) @(negedge clk);
         chk(ncap == 30, "R11", "single frame length", ncap, 30);
         chk_bytes("R11", ba, 30, 0);
         chk(nwrites == 1, "R11", "single write-back", nwrites, 1);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule